// File: doc/BRIEF.md
# Fault-Aware Reference Amplitude Limiter

This block sits in front of the vector selection stage of a three-phase modulator for an inverter built from cascaded cells. One input gives the number of bypassed (faulty) cells in each phase. From these counts, for each of the six sectors of the hexagon, it works out how many outer rings of space vectors can no longer be produced. It also finds the worst ring count over all six sectors. From that worst count it forms the largest magnitude that stays inside the biggest hexagon the remaining healthy cells can still build. It limits an incoming reference magnitude to that value.

Magnitudes are unsigned fixed-point numbers. One ring of vectors corresponds to `LAYER_STEP` units. That unit is the cell DC voltage divided by the square root of three, already expressed in the caller's scale. So the usable limit is `(LEVELS-1-worst) * LAYER_STEP`, and no divider is needed. The block also reports the usable fraction of the healthy range as a fixed-point ratio. An input sample is presented with `in_valid`, and its result appears one clock later with `out_valid`.

Top module: `fault_amp_limiter`

## Requirements
- R1: The ring count for sectors I and IV is the phase A fault count plus the phase C fault count. Sector s (I..VI as s = 0..5) occupies bits `[s*(CNT_W+1) +: CNT_W+1]` of `sec_layers`.
- R2: The ring count for sectors II and V is B+C, and for sectors III and VI it is A+B. A fault in phase A alone therefore leaves sectors II and V at zero.
- R3: `worst_layers` is the maximum of the three pairwise sums.
- R4: The limit is `(LEVELS-1-worst_layers) * LAYER_STEP`. With 11 levels and a step of 3000, the healthy limit is 30000. One ring gives 27000 (90 %) and five rings give 15000 (50 %).
- R5: A reference at or below the limit passes to `out_mag` unchanged, with `out_clamped` low.
- R6: A reference above the limit produces `out_mag` equal to the limit, with `out_clamped` high for that one output cycle.
- R7: `ratio` equals `(LEVELS-1-worst_layers) * floor(2^RATIO_F/(LEVELS-1))`. For 11 levels and RATIO_F = 15 that is `usable * 3276`.
- R8: When any phase count exceeds `(LEVELS-1)/2`, `out_err` is high and both the limit and `ratio` become 0. Any nonzero reference is then clamped to 0. The raw sums are still reported.
- R9: `out_valid` follows `in_valid` by exactly one clock. While `in_valid` is low, the inputs are ignored: the data outputs hold their last values and `out_clamped` is low.
- R10: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample present |
| fault_a | input | CNT_W | Bypassed cells in phase A |
| fault_b | input | CNT_W | Bypassed cells in phase B |
| fault_c | input | CNT_W | Bypassed cells in phase C |
| ref_mag | input | MAG_W | Requested reference magnitude |
| out_valid | output | 1 | Result present |
| out_mag | output | MAG_W | Limited reference magnitude |
| out_clamped | output | 1 | Reference was reduced this cycle |
| out_err | output | 1 | A fault count is out of range |
| sec_layers | output | 6*(CNT_W+1) | Unusable ring count per sector |
| worst_layers | output | CNT_W+1 | Largest per-sector ring count |
| ratio | output | RATIO_F+1 | Usable fraction of the healthy range |

## Verification
The only state in the block is the output register, and every result is formed in one combinational pass. A wrong pairing of phases or a wrong maximum therefore shows up in `sec_layers` or `worst_layers` on the very `out_valid` cycle of the offending sample. Reference magnitudes placed exactly at the limit, just above it and far above it separate a comparison that is off by one from a correct one. A sweep over every legal fault combination compares each output against a model built from the formulas. Samples presented with `in_valid` low, followed by an idle cycle, show whether the output register wrongly updates or leaves the clamp flag asserted.

// File: rtl/fal_pkg.sv
package fal_pkg;
   // Number of sectors in the hexagon
   localparam int unsigned SECTORS = 6;

   // Fixed-point reciprocal of the healthy ring count (truncated)
   function automatic int unsigned recip_q(input int unsigned levels, input int unsigned frac);
      return (32'd1 << frac) / (levels - 1);
   endfunction

   // Phase pair feeding a sector: 0 -> A+C, 1 -> B+C, 2 -> A+B
   function automatic int unsigned pair_of(input int unsigned sector);
      return sector % 3;
   endfunction
endpackage

// File: rtl/fal_layer_calc.sv
module fal_layer_calc #(
   parameter int unsigned LEVELS = 11,
   parameter int unsigned CNT_W  = 4,
   localparam int unsigned LW    = CNT_W + 1
) (
   input  logic [CNT_W-1:0]            cnt_a,
   input  logic [CNT_W-1:0]            cnt_b,
   input  logic [CNT_W-1:0]            cnt_c,
   output logic [fal_pkg::SECTORS*LW-1:0] sec_cnt,
   output logic [LW-1:0]               worst,
   output logic                        bad_cnt
);
   localparam int unsigned HALF = (LEVELS - 1) / 2;

   logic [LW-1:0] sum_ac, sum_bc, sum_ab, max_1;

   assign sum_ac = LW'(cnt_a) + LW'(cnt_c);
   assign sum_bc = LW'(cnt_b) + LW'(cnt_c);
   assign sum_ab = LW'(cnt_a) + LW'(cnt_b);

   for (genvar s = 0; s < fal_pkg::SECTORS; s++) begin : g_sec
      if (fal_pkg::pair_of(s) == 0) begin : g_ac
         assign sec_cnt[s*LW +: LW] = sum_ac;
      end else if (fal_pkg::pair_of(s) == 1) begin : g_bc
         assign sec_cnt[s*LW +: LW] = sum_bc;
      end else begin : g_ab
         assign sec_cnt[s*LW +: LW] = sum_ab;
      end
   end

   assign max_1   = (sum_ac > sum_bc) ? sum_ac : sum_bc;
   assign worst   = (max_1 > sum_ab) ? max_1 : sum_ab;
   assign bad_cnt = (cnt_a > CNT_W'(HALF)) | (cnt_b > CNT_W'(HALF)) | (cnt_c > CNT_W'(HALF));
endmodule

// File: rtl/fal_limit_scale.sv
module fal_limit_scale #(
   parameter int unsigned LEVELS     = 11,
   parameter int unsigned CNT_W      = 4,
   parameter int unsigned MAG_W      = 16,
   parameter int unsigned LAYER_STEP = 3000,
   parameter int unsigned RATIO_F    = 15,
   localparam int unsigned LW        = CNT_W + 1,
   localparam int unsigned RW        = RATIO_F + 1
) (
   input  logic [LW-1:0]    worst,
   input  logic             bad_cnt,
   output logic [MAG_W-1:0] limit,
   output logic [RW-1:0]    ratio
);
   localparam int unsigned RECIP   = fal_pkg::recip_q(LEVELS, RATIO_F);
   localparam bit          STEP_P2 = (LAYER_STEP & (LAYER_STEP - 1)) == 0;
   localparam int unsigned STEP_SH = $clog2(LAYER_STEP);

   logic [LW-1:0] usable;

   // Rings still available; forced to zero for an illegal count
   assign usable = bad_cnt ? '0 : (LW'(LEVELS - 1) - worst);

   if (STEP_P2) begin : g_shift
      assign limit = MAG_W'(usable) << STEP_SH;
   end else begin : g_mult
      assign limit = MAG_W'(usable) * MAG_W'(LAYER_STEP);
   end

   assign ratio = RW'(usable) * RW'(RECIP);
endmodule

// File: rtl/fal_clamp.sv
module fal_clamp #(
   parameter int unsigned MAG_W = 16
) (
   input  logic [MAG_W-1:0] ref_mag,
   input  logic [MAG_W-1:0] limit,
   output logic [MAG_W-1:0] mag,
   output logic             over
);
   assign over = ref_mag > limit;
   assign mag  = over ? limit : ref_mag;
endmodule

// File: rtl/fault_amp_limiter.sv
module fault_amp_limiter #(
   parameter int unsigned LEVELS     = 11,
   parameter int unsigned CNT_W      = 4,
   parameter int unsigned MAG_W      = 16,
   parameter int unsigned LAYER_STEP = 3000,
   parameter int unsigned RATIO_F    = 15
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_valid,
   input  logic [CNT_W-1:0]              fault_a,
   input  logic [CNT_W-1:0]              fault_b,
   input  logic [CNT_W-1:0]              fault_c,
   input  logic [MAG_W-1:0]              ref_mag,
   output logic                          out_valid,
   output logic [MAG_W-1:0]              out_mag,
   output logic                          out_clamped,
   output logic                          out_err,
   output logic [6*(CNT_W+1)-1:0]        sec_layers,
   output logic [CNT_W:0]                worst_layers,
   output logic [RATIO_F:0]              ratio
);
   localparam int unsigned LW   = CNT_W + 1;
   localparam int unsigned RW   = RATIO_F + 1;
   localparam int unsigned HALF = (LEVELS - 1) / 2;

   // Elaboration-time parameter checks
   if (LEVELS < 3 || (LEVELS % 2) == 0) begin : g_chk_levels
      $error("LEVELS must be odd and at least 3");
   end
   if (HALF >= (1 << CNT_W)) begin : g_chk_cnt
      $error("CNT_W too narrow for the per-phase cell count");
   end
   if (LAYER_STEP == 0 || (LAYER_STEP * (LEVELS - 1)) >= (1 << MAG_W)) begin : g_chk_mag
      $error("healthy limit does not fit in MAG_W");
   end
   if (LW > RW || RATIO_F > 30) begin : g_chk_ratio
      $error("RATIO_F out of range");
   end

   logic [6*LW-1:0] sec_w;
   logic [LW-1:0]   worst_w;
   logic            bad_w, over_w;
   logic [MAG_W-1:0] limit_w, mag_w;
   logic [RW-1:0]   ratio_w;

   fal_layer_calc #(.LEVELS(LEVELS), .CNT_W(CNT_W)) u_layers (
      .cnt_a(fault_a), .cnt_b(fault_b), .cnt_c(fault_c),
      .sec_cnt(sec_w), .worst(worst_w), .bad_cnt(bad_w)
   );

   fal_limit_scale #(
      .LEVELS(LEVELS), .CNT_W(CNT_W), .MAG_W(MAG_W),
      .LAYER_STEP(LAYER_STEP), .RATIO_F(RATIO_F)
   ) u_scale (
      .worst(worst_w), .bad_cnt(bad_w), .limit(limit_w), .ratio(ratio_w)
   );

   fal_clamp #(.MAG_W(MAG_W)) u_clamp (
      .ref_mag(ref_mag), .limit(limit_w), .mag(mag_w), .over(over_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_clamped  <= 1'b0;
         out_mag      <= '0;
         out_err      <= 1'b0;
         sec_layers   <= '0;
         worst_layers <= '0;
         ratio        <= '0;
      end else begin
         out_valid   <= in_valid;
         out_clamped <= in_valid & over_w;
         if (in_valid) begin
            out_mag      <= mag_w;
            out_err      <= bad_w;
            sec_layers   <= sec_w;
            worst_layers <= worst_w;
            ratio        <= ratio_w;
         end
      end
   end

   // Latency of one clock, in both directions
   assert_valid_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_valid_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_mag) && $stable(worst_layers) && $stable(ratio)));

   // Clamp flag only with a result
   assert_clamp_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_clamped |-> out_valid);
   assert_never_grow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_mag <= $past(ref_mag));
   assert_passthru_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_clamped) |-> out_mag == $past(ref_mag));

   // Worst count dominates all sectors; opposite sectors agree
   assert_worst_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (worst_layers >= sec_layers[0 +: LW] &&
                     worst_layers >= sec_layers[LW +: LW] &&
                     worst_layers >= sec_layers[2*LW +: LW]));
   assert_mirror_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> sec_layers[0 +: LW] == sec_layers[3*LW +: LW]);

   // Illegal count zeroes the usable range
   assert_err_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_err) |-> (ratio == '0 && out_mag == '0));
endmodule

// File: tb/sim_fault_amp_limiter.sv
module sim_fault_amp_limiter;
   localparam int LW = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [3:0]  fault_a = '0, fault_b = '0, fault_c = '0;
   logic [15:0] ref_mag = '0;
   logic        out_valid, out_clamped, out_err;
   logic [15:0] out_mag, ratio;
   logic [29:0] sec_layers;
   logic [4:0]  worst_layers;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   fault_amp_limiter u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .fault_a(fault_a), .fault_b(fault_b), .fault_c(fault_c), .ref_mag(ref_mag),
      .out_valid(out_valid), .out_mag(out_mag), .out_clamped(out_clamped),
      .out_err(out_err), .sec_layers(sec_layers), .worst_layers(worst_layers),
      .ratio(ratio)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int sec(input int s);
      return int'((sec_layers >> (s * LW)) & 30'h1f);
   endfunction

   // Present one sample, then check the registered result
   task automatic apply(input int a, input int b, input int c, input int mag);
      int sac, sbc, sab, w, usable, lim, expm;
      bit bad;
      @(negedge clk);
      fault_a = 4'(a); fault_b = 4'(b); fault_c = 4'(c); ref_mag = 16'(mag);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      sac = a + c; sbc = b + c; sab = a + b;
      w = (sac > sbc) ? sac : sbc;
      w = (w > sab) ? w : sab;
      bad = (a > 5) || (b > 5) || (c > 5);
      usable = bad ? 0 : 10 - w;
      lim = usable * 3000;
      expm = (mag > lim) ? lim : mag;
      chk("R9", "out_valid", int'(out_valid), 1);
      chk("R1", "sector I", sec(0), sac);
      chk("R1", "sector IV", sec(3), sac);
      chk("R2", "sector II", sec(1), sbc);
      chk("R2", "sector V", sec(4), sbc);
      chk("R2", "sector III", sec(2), sab);
      chk("R2", "sector VI", sec(5), sab);
      chk("R3", "worst", int'(worst_layers), w);
      chk("R4", "out_mag", int'(out_mag), expm);
      chk("R6", "clamped", int'(out_clamped), int'(mag > lim));
      chk("R7", "ratio", int'(ratio), usable * 3276);
      chk("R8", "err", int'(out_err), int'(bad));
   endtask

   task automatic t_reset;
      chk("R10", "out_valid", int'(out_valid), 0);
      chk("R10", "out_mag", int'(out_mag), 0);
      chk("R10", "clamped", int'(out_clamped), 0);
      chk("R10", "err", int'(out_err), 0);
      chk("R10", "sec_layers", int'(sec_layers), 0);
      chk("R10", "worst", int'(worst_layers), 0);
      chk("R10", "ratio", int'(ratio), 0);
   endtask

   task automatic t_healthy;
      apply(0, 0, 0, 25000);
      chk("R5", "healthy pass", int'(out_mag), 25000);
      apply(0, 0, 0, 30000);
      chk("R5", "at limit pass", int'(out_clamped), 0);
      apply(0, 0, 0, 30001);
      chk("R6", "just above", int'(out_mag), 30000);
      chk("R7", "full ratio", int'(ratio), 32760);
   endtask

   task automatic t_phase_a;
      apply(1, 0, 0, 28000);
      chk("R2", "sector II untouched", sec(1), 0);
      chk("R2", "sector V untouched", sec(4), 0);
      chk("R4", "90 percent limit", int'(out_mag), 27000);
      chk("R6", "clamp at 90", int'(out_clamped), 1);
      apply(1, 0, 0, 27000);
      chk("R5", "equal 90 limit", int'(out_clamped), 0);
   endtask

   task automatic t_five;
      apply(1, 2, 3, 40000);
      chk("R3", "worst five", int'(worst_layers), 5);
      chk("R4", "50 percent limit", int'(out_mag), 15000);
   endtask

   task automatic t_empty;
      apply(5, 0, 5, 1);
      chk("R4", "no rings left", int'(out_mag), 0);
      chk("R6", "clamp to zero", int'(out_clamped), 1);
      apply(5, 0, 5, 0);
      chk("R5", "zero ref no clamp", int'(out_clamped), 0);
   endtask

   task automatic t_error;
      apply(6, 0, 1, 100);
      chk("R8", "error flag", int'(out_err), 1);
      chk("R8", "zero output", int'(out_mag), 0);
      chk("R8", "raw sum kept", sec(0), 7);
      apply(0, 0, 9, 0);
      chk("R8", "error on C", int'(out_err), 1);
      apply(2, 2, 2, 5000);
      chk("R8", "error clears", int'(out_err), 0);
   endtask

   task automatic t_idle;
      apply(1, 0, 0, 29000);
      @(negedge clk);
      fault_a = 4'd5; fault_b = 4'd5; ref_mag = 16'd100;
      @(negedge clk);
      chk("R9", "valid drops", int'(out_valid), 0);
      chk("R9", "clamp drops", int'(out_clamped), 0);
      chk("R9", "mag held", int'(out_mag), 27000);
      chk("R9", "worst held", int'(worst_layers), 1);
      chk("R9", "ratio held", int'(ratio), 9 * 3276);
   endtask

   task automatic t_sweep;
      for (int a = 0; a <= 5; a++)
         for (int b = 0; b <= 5; b++)
            for (int c = 0; c <= 5; c++)
               apply(a, b, c, 13000 + a * 1700 + c * 300);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_healthy();
      t_phase_a();
      t_five();
      t_empty();
      t_error();
      t_idle();
      t_sweep();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule